// File: doc/BRIEF.md
# Stereo Serial Audio Master Port

This block is the serial audio port of an audio interface chip. It is always the master of the link. It forwards the master clock it is given, and derives from it a bit clock and a left/right word clock. External converters or signal processors act as slaves on this link. A 12.288 MHz master clock gives 48 kHz sampling and 11.2896 MHz gives 44.1 kHz, because the frame is always 256 master clocks long. Each frame has 64 bit periods, which is 32 bit slots per channel.

Playback samples come in through a valid/ready handshake, one stereo pair per frame. Each pair is shifted out MSB first, one bit clock after the word clock edge as standard I2S timing requires. The same pair is handed to the on-chip DAC path in the same cycle. On the record side, only the left slot of the serial input is captured, because recording is mono. A select input decides whether recorded samples come from that serial input or from the internal ADC path. In both cases they leave through a valid strobe.

Top module: `i2s_master_port`

## Requirements
- R1: While reset is held, `bclk_o`, `lrck_o`, `sdout_o`, `dac_valid`, `rec_valid` and the data outputs are 0, and `play_ready` is 1.
- R2: `bclk_o` has a period of 4 master clocks. It is low for the first 2 and high for the last 2 master clocks of each bit period. The first bit period starts with the first master clock edge after reset.
- R3: `lrck_o` is 0 for bit periods 0 to 31 of each 64-bit frame (the left channel) and 1 for bit periods 32 to 63. It changes only where `bclk_o` falls.
- R4: `sdout_o` carries the left word MSB first in bit periods 1 to 16 and the right word in bit periods 33 to 48. All other bit periods carry 0. It changes only where `bclk_o` falls.
- R5: `play_ready` is 1 whenever the one-entry holding register is empty. A pair offered with `play_valid` while ready is taken on that edge, and ready then drops. The held pair moves into the output frame at the next frame start, and the register empties. A frame that starts with nothing held sends zeros.
- R6: `dac_valid` pulses for one cycle at each frame start. While it is high, `dac_left`/`dac_right` hold the pair that the serial output sends in that frame.
- R7: With `rec_src_sel` = 1, the input `sdin_i` is sampled where `bclk_o` rises in bit periods 1 to 16. When bit period 17 begins, those 16 bits come out on `rec_data`, first-sampled bit as the MSB, with a one-cycle `rec_valid`.
- R8: Bits on `sdin_i` outside left bit periods 1 to 16, including the whole right slot, have no effect on `rec_data`. Serial capture gives at most one `rec_valid` per frame.
- R9: With `rec_src_sel` = 0, each cycle that has `adc_valid` high gives `rec_valid` = 1 and `rec_data` = `adc_data` on the next cycle, and completed serial words are dropped. With `rec_src_sel` = 1, `adc_valid` is ignored.
- R10: `mclk_o` is the master clock input passed straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_valid | input | 1 | Playback pair offered |
| play_ready | output | 1 | Holding register empty |
| play_left | input | 16 | Playback left sample |
| play_right | input | 16 | Playback right sample |
| dac_valid | output | 1 | Frame-start strobe for the DAC path |
| dac_left | output | 16 | Left sample of the current frame |
| dac_right | output | 16 | Right sample of the current frame |
| adc_valid | input | 1 | Internal ADC sample strobe |
| adc_data | input | 16 | Internal ADC sample |
| rec_src_sel | input | 1 | Record source: 1 serial input, 0 internal ADC |
| rec_valid | output | 1 | Recorded sample strobe |
| rec_data | output | 16 | Recorded mono sample |
| mclk_o | output | 1 | Master clock out to the slaves |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word clock, 0 for the left channel |
| sdout_o | output | 1 | Serial playback data |
| sdin_i | input | 1 | Serial record data |

## Verification
Playback runs first with no sample held, then with words whose patterns set apart the cases that matter. A5C3/1234 is asymmetric, so a reversed bit order or swapped channels shows up. FFFF/0000 and 0000/FFFF mark where each slot starts and ends, so an off-by-one delay is visible. 8001/7FFE tests MSB and LSB placement. Samples are also offered back to back, so that ready stalls across frame boundaries. On the record side, the slave model fills the right slot and the unused slots with pseudo-random bits that a correct capture must ignore. The record source is then switched mid-run while ADC strobes arrive, both singly and back to back, so that each source's path is shown to be blocked when it is not selected.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
   typedef enum logic {
      SRC_ADC    = 1'b0,
      SRC_SERIAL = 1'b1
   } rec_src_e;

   localparam int unsigned MIN_SAMPLE_W = 2;
endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
   parameter int unsigned BCLK_DIV = 4,
   parameter int unsigned SLOT_W   = 32,
   localparam int unsigned PH_W    = $clog2(BCLK_DIV),
   localparam int unsigned BIT_W   = $clog2(2 * SLOT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             bclk_o,
   output logic             lrck_o,
   output logic             bit_start_o,
   output logic             bit_rise_o,
   output logic             frame_start_o,
   output logic [BIT_W-1:0] bit_idx_o
);
   localparam int unsigned CNT_W = PH_W + BIT_W;

   generate
      if (BCLK_DIV < 2 || (1 << PH_W) != BCLK_DIV) begin : g_bad_div
         $error("BCLK_DIV must be a power of two, at least 2");
      end
      if ((1 << BIT_W) != 2 * SLOT_W) begin : g_bad_slot
         $error("SLOT_W must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [PH_W-1:0]  ph_nxt;
   logic             bclk_q;
   logic             lrck_q;

   assign cnt_nxt       = cnt_q + 1'b1;
   assign ph_nxt        = cnt_nxt[PH_W-1:0];
   assign bit_idx_o     = cnt_nxt[CNT_W-1:PH_W];
   assign bit_start_o   = (ph_nxt == '0);
   assign bit_rise_o    = (ph_nxt == PH_W'(BCLK_DIV / 2));
   assign frame_start_o = (cnt_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
         lrck_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         bclk_q <= ph_nxt[PH_W-1];
         lrck_q <= bit_idx_o[BIT_W-1];
      end
   end

   assign bclk_o = bclk_q;
   assign lrck_o = lrck_q;

   // R3: word clock moves only together with a falling bit clock
   p_lrck_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lrck_q) |-> $fell(bclk_q));
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned SLOT_W   = 32,
   localparam int unsigned BIT_W   = $clog2(2 * SLOT_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic                bit_start,
   input  logic [BIT_W-1:0]    bit_idx,
   input  logic                play_valid,
   output logic                play_ready,
   input  logic [SAMPLE_W-1:0] play_left,
   input  logic [SAMPLE_W-1:0] play_right,
   output logic                dac_valid,
   output logic [SAMPLE_W-1:0] dac_left,
   output logic [SAMPLE_W-1:0] dac_right,
   output logic                sdout
);
   localparam int unsigned POS_W = BIT_W - 1;

   generate
      if (SAMPLE_W >= SLOT_W || SAMPLE_W < i2s_pkg::MIN_SAMPLE_W) begin : g_bad_w
         $error("SAMPLE_W must fit in a slot after the one-bit delay");
      end
   endgenerate

   logic                pend_q;
   logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
   logic [SAMPLE_W-1:0] fr_l_q, fr_r_q;
   logic                dac_valid_q;
   logic                sdout_q;
   logic [POS_W-1:0]    pos;
   logic [SAMPLE_W-1:0] word, shifted;
   logic                in_field;
   logic                bit_val;

   assign play_ready = !pend_q;
   assign pos        = bit_idx[POS_W-1:0];
   assign word       = bit_idx[BIT_W-1] ? fr_r_q : fr_l_q;
   assign in_field   = (pos >= POS_W'(1)) && (pos <= POS_W'(SAMPLE_W));
   assign shifted    = word << (pos - 1'b1);
   assign bit_val    = in_field & shifted[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_l_q    <= '0;
         pend_r_q    <= '0;
         fr_l_q      <= '0;
         fr_r_q      <= '0;
         dac_valid_q <= 1'b0;
         sdout_q     <= 1'b0;
      end else begin
         dac_valid_q <= frame_start;
         if (frame_start) begin
            fr_l_q <= pend_q ? pend_l_q : '0;
            fr_r_q <= pend_q ? pend_r_q : '0;
            pend_q <= 1'b0;
         end
         if (play_valid && play_ready) begin
            pend_q   <= 1'b1;
            pend_l_q <= play_left;
            pend_r_q <= play_right;
         end
         if (bit_start) sdout_q <= bit_val;
      end
   end

   assign dac_valid = dac_valid_q;
   assign dac_left  = fr_l_q;
   assign dac_right = fr_r_q;
   assign sdout     = sdout_q;

   // R5: a taken pair fills the holding register
   p_accept_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (play_valid && play_ready) |=> !play_ready);
   // R6: the DAC strobe is a single-cycle pulse
   p_dac_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_valid |=> !dac_valid);
endmodule

// File: rtl/i2s_rx.sv
module i2s_rx #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned SLOT_W   = 32,
   localparam int unsigned BIT_W   = $clog2(2 * SLOT_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_start,
   input  logic                bit_rise,
   input  logic [BIT_W-1:0]    bit_idx,
   input  logic                sdin,
   input  logic                src_sel,
   input  logic                adc_valid,
   input  logic [SAMPLE_W-1:0] adc_data,
   output logic                rec_valid,
   output logic [SAMPLE_W-1:0] rec_data
);
   localparam int unsigned POS_W = BIT_W - 1;

   logic [SAMPLE_W-1:0] sh_q;
   logic [SAMPLE_W-1:0] data_q;
   logic                valid_q;
   logic [POS_W-1:0]    pos;
   logic                capture;
   logic                word_done;
   logic                use_serial;

   assign pos        = bit_idx[POS_W-1:0];
   assign capture    = bit_rise && !bit_idx[BIT_W-1] &&
                       (pos >= POS_W'(1)) && (pos <= POS_W'(SAMPLE_W));
   assign word_done  = bit_start && (bit_idx == BIT_W'(SAMPLE_W + 1));
   assign use_serial = (i2s_pkg::rec_src_e'(src_sel) == i2s_pkg::SRC_SERIAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (capture) sh_q <= {sh_q[SAMPLE_W-2:0], sdin};
         if (use_serial && word_done) begin
            valid_q <= 1'b1;
            data_q  <= sh_q;
         end else if (!use_serial && adc_valid) begin
            valid_q <= 1'b1;
            data_q  <= adc_data;
         end
      end
   end

   assign rec_valid = valid_q;
   assign rec_data  = data_q;

   // R8: serial capture yields no two words in a row
   p_one_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && src_sel) |=> !(rec_valid && src_sel));
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned SLOT_W   = 32,
   parameter int unsigned BCLK_DIV = 4
) (
   input  logic                mclk,
   input  logic                rst_n,
   input  logic                play_valid,
   output logic                play_ready,
   input  logic [SAMPLE_W-1:0] play_left,
   input  logic [SAMPLE_W-1:0] play_right,
   output logic                dac_valid,
   output logic [SAMPLE_W-1:0] dac_left,
   output logic [SAMPLE_W-1:0] dac_right,
   input  logic                adc_valid,
   input  logic [SAMPLE_W-1:0] adc_data,
   input  logic                rec_src_sel,
   output logic                rec_valid,
   output logic [SAMPLE_W-1:0] rec_data,
   output logic                mclk_o,
   output logic                bclk_o,
   output logic                lrck_o,
   output logic                sdout_o,
   input  logic                sdin_i
);
   localparam int unsigned BIT_W = $clog2(2 * SLOT_W);

   logic             bit_start, bit_rise, frame_start;
   logic [BIT_W-1:0] bit_idx;

   // R10: slaves run from the same master clock
   assign mclk_o = mclk;

   i2s_clkgen #(.BCLK_DIV(BCLK_DIV), .SLOT_W(SLOT_W)) u_clkgen (
      .clk(mclk), .rst_n(rst_n), .bclk_o(bclk_o), .lrck_o(lrck_o),
      .bit_start_o(bit_start), .bit_rise_o(bit_rise),
      .frame_start_o(frame_start), .bit_idx_o(bit_idx)
   );

   i2s_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
      .clk(mclk), .rst_n(rst_n), .frame_start(frame_start),
      .bit_start(bit_start), .bit_idx(bit_idx),
      .play_valid(play_valid), .play_ready(play_ready),
      .play_left(play_left), .play_right(play_right),
      .dac_valid(dac_valid), .dac_left(dac_left), .dac_right(dac_right),
      .sdout(sdout_o)
   );

   i2s_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
      .clk(mclk), .rst_n(rst_n), .bit_start(bit_start), .bit_rise(bit_rise),
      .bit_idx(bit_idx), .sdin(sdin_i), .src_sel(rec_src_sel),
      .adc_valid(adc_valid), .adc_data(adc_data),
      .rec_valid(rec_valid), .rec_data(rec_data)
   );

   // R4: serial data move only on a falling bit clock
   p_sdout_on_fall_r4: assert property (@(posedge mclk) disable iff (!rst_n)
      !$stable(sdout_o) |-> $fell(bclk_o));
endmodule

// File: tb/i2s_master_port_bench.sv
`timescale 1ns/1ps
module i2s_master_port_bench;
   localparam int W = 16, S = 32, D = 4, FRAME = 2 * S * D;

   logic mclk = 1'b0, rst_n = 1'b0;
   logic play_valid = 1'b0;
   logic [W-1:0] play_left = '0, play_right = '0;
   logic adc_valid = 1'b0;
   logic [W-1:0] adc_data = '0;
   logic rec_src_sel = 1'b1;
   logic sdin_i = 1'b0;
   logic play_ready, dac_valid, rec_valid, mclk_o, bclk_o, lrck_o, sdout_o;
   logic [W-1:0] dac_left, dac_right, rec_data;

   int checks = 0, fails = 0;

   i2s_master_port u_i2s_master_port (
      .mclk(mclk), .rst_n(rst_n), .play_valid(play_valid), .play_ready(play_ready),
      .play_left(play_left), .play_right(play_right), .dac_valid(dac_valid),
      .dac_left(dac_left), .dac_right(dac_right), .adc_valid(adc_valid),
      .adc_data(adc_data), .rec_src_sel(rec_src_sel), .rec_valid(rec_valid),
      .rec_data(rec_data), .mclk_o(mclk_o), .bclk_o(bclk_o), .lrck_o(lrck_o),
      .sdout_o(sdout_o), .sdin_i(sdin_i)
   );

   always #5 mclk = ~mclk;

   // reference model state
   int m_cnt = 0;
   bit m_pend = 0;
   logic [W-1:0] m_pl = '0, m_pr = '0, m_fl = '0, m_fr = '0, m_sh = '0;
   logic e_bclk = 0, e_lrck = 0, e_sdout = 0, e_dac_valid = 0, e_rec_valid = 0;
   logic [W-1:0] e_rec_data = '0;
   logic [W-1:0] sl_left = 16'h0F0F, sl_right = 16'hF00F;
   logic [31:0] lcg = 32'h1234_5678;

   always @(posedge mclk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pend = 0; m_pl = '0; m_pr = '0; m_fl = '0; m_fr = '0; m_sh = '0;
         e_bclk = 0; e_lrck = 0; e_sdout = 0; e_dac_valid = 0;
         e_rec_valid = 0; e_rec_data = '0;
      end else begin
         int nxt, ph, b, pos, ch;
         bit acc;
         nxt = (m_cnt + 1) % FRAME;
         ph = nxt % D; b = nxt / D; pos = b % S; ch = b / S;
         e_rec_valid = 0;
         if (ph == D / 2 && ch == 0 && pos >= 1 && pos <= W)
            m_sh = {m_sh[W-2:0], sdin_i};
         if (ph == 0 && b == W + 1 && rec_src_sel) begin
            e_rec_valid = 1; e_rec_data = m_sh;
         end else if (!rec_src_sel && adc_valid) begin
            e_rec_valid = 1; e_rec_data = adc_data;
         end
         acc = play_valid && !m_pend;
         e_dac_valid = (nxt == 0);
         if (nxt == 0) begin
            m_fl = m_pend ? m_pl : '0;
            m_fr = m_pend ? m_pr : '0;
            m_pend = 0;
         end
         if (acc) begin m_pend = 1; m_pl = play_left; m_pr = play_right; end
         if (ph == 0) begin
            if (pos >= 1 && pos <= W) e_sdout = ch ? m_fr[W-pos] : m_fl[W-pos];
            else e_sdout = 0;
         end
         e_bclk = (ph >= D / 2);
         e_lrck = ch[0];
         m_cnt = nxt;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge mclk) begin
      string t;
      t = rst_n ? "" : "R1 ";
      check(mclk_o === 1'b0, "R10 mclk_o", mclk_o, 0);
      check(bclk_o === e_bclk, {t, "R2 bclk"}, bclk_o, e_bclk);
      check(lrck_o === e_lrck, {t, "R3 lrck"}, lrck_o, e_lrck);
      check(sdout_o === e_sdout, {t, "R4 sdout"}, sdout_o, e_sdout);
      check(play_ready === !m_pend, {t, "R5 play_ready"}, play_ready, !m_pend);
      check(dac_valid === e_dac_valid, {t, "R6 dac_valid"}, dac_valid, e_dac_valid);
      check(dac_left === m_fl && dac_right === m_fr, {t, "R6 dac words"},
            {dac_left, dac_right}, {m_fl, m_fr});
      check(rec_valid === e_rec_valid, {t, "R7/R9 rec_valid"}, rec_valid, e_rec_valid);
      if (e_rec_valid)
         check(rec_data === e_rec_data, "R7 R8 R9 rec_data", rec_data, e_rec_data);
   end

   // slave serial source: new word each frame, junk in the right slot and unused bits
   always @(negedge mclk) begin
      if (rst_n) begin
         int b, pos, ch;
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         if (m_cnt == 0) begin sl_left = lcg[31:16]; sl_right = lcg[15:0]; end
         b = m_cnt / D; pos = b % S; ch = b / S;
         if (ch == 0 && pos >= 1 && pos <= W) sdin_i = sl_left[W-pos];
         else sdin_i = lcg[20];
      end
   end

   task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
      @(negedge mclk);
      while (m_pend) @(negedge mclk);
      play_valid = 1'b1; play_left = l; play_right = r;
      @(negedge mclk);
      play_valid = 1'b0;
   endtask

   task automatic adc_pulse(input logic [W-1:0] d);
      @(negedge mclk);
      adc_valid = 1'b1; adc_data = d;
      @(negedge mclk);
      adc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge mclk);
   endtask

   task automatic finish_run;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(6);                      // R1 checked while reset held
      rst_n = 1'b1;
      idle(300);                    // R4 R6: empty frames send zeros
      push(16'hA5C3, 16'h1234);     // R4 R5 bit order and channel
      push(16'hFFFF, 16'h0000);     // R4 slot edges
      push(16'h8001, 16'h7FFE);
      push(16'h0000, 16'hFFFF);
      push(16'h0001, 16'h8000);
      idle(600);                    // R7 R8 serial record
      rec_src_sel = 1'b0;           // R9 ADC source
      adc_pulse(16'hBEEF);
      idle(40);
      @(negedge mclk);
      adc_valid = 1'b1; adc_data = 16'h1111;
      @(negedge mclk);
      adc_data = 16'h2222;
      @(negedge mclk);
      adc_valid = 1'b0;
      push(16'h5A5A, 16'hC33C);
      idle(600);
      rec_src_sel = 1'b1;           // R9 ADC strobes ignored
      adc_pulse(16'hDEAD);
      idle(700);
      finish_run();
   end
endmodule